// File: doc/BRIEF.md
# Text and Bitmap Pixel Generator

This block sits between a raster timing generator and the display memory of a 640x480 video output. On every clock it takes the current pixel position and an active-area flag, forms a fetch address into video memory, and turns the returned word into one pixel of 3-bit red, green and blue. The default mode is character text: the screen is a grid of 80 by 60 cells of 8x8 pixels. Each cell is one 16-bit memory word. Its low byte is a character code, which indexes an internal glyph generator. Its high byte is a colour attribute.

A mode input switches to a one-bit-per-pixel bitmap. In that mode each memory byte covers eight horizontally adjacent pixels, and the colours come from the default attribute. A linear scroll offset is added to every fetch address in both modes. In text mode a hardware cursor marks one cell by exchanging its foreground and background colours. Sync generation and arbitration of the memory are outside the block. The memory is expected to return data one clock after it sees an address.

Top module: `vid_pixel_gen`

## Requirements
- R1: In text mode the fetch address is (pix_y/8)*80 + pix_x/8 + scroll_off, modulo 2^16. The memory word read there holds the character code in bits 7:0 and the attribute in bits 15:8.
- R2: Row r (pix_y mod 8) of the glyph for code c is c rotated left by r bit places. Bit 7 of a glyph row is the leftmost pixel of the cell, at pix_x mod 8 = 0.
- R3: Attribute bits 0, 1 and 2 are the foreground red, green and blue, and bit 3 is the foreground brightness. Bits 4 to 7 are the same four fields for the background. A set pixel takes the foreground, a clear pixel the background.
- R4: When the fetched attribute byte is zero, default_attr is used in its place.
- R5: scroll_off is added to every fetch address. A value of 80 moves the text image up by one character row, and the sum wraps at 2^16.
- R6: In text mode the cell whose fetch address equals cursor_pos is drawn with foreground and background exchanged. In bitmap mode the cursor has no effect.
- R7: Each colour output is 0 when its bit is clear. It is 5 when its bit is set and brightness is clear, and 7 when both are set.
- R8: A pixel presented with pix_de low produces zero on all colour outputs.
- R9: With mode_bitmap high, the fetch address is pix_y*80 + pix_x/8 + scroll_off. Bit (7 - pix_x mod 8) of the low data byte selects the foreground (1) or background (0) of default_attr.
- R10: The colour for a pixel presented in one cycle appears on the outputs two rising edges later.
- R11: While rst_n is low, all colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel line |
| pix_de | input | 1 | High inside the active area |
| mode_bitmap | input | 1 | 1 selects the 1-bit bitmap, 0 selects text |
| scroll_off | input | 16 | Linear offset added to fetch addresses |
| cursor_pos | input | 16 | Memory address of the cursor cell |
| default_attr | input | 8 | Attribute used for zero attributes and for bitmap mode |
| mem_addr | output | 16 | Video memory word address |
| mem_rdata | input | 16 | Memory word, valid one cycle after its address |
| vga_r | output | 3 | Red level |
| vga_g | output | 3 | Green level |
| vga_b | output | 3 | Blue level |

## Verification
Some properties are checked on every cycle. The fetch address must stay constant while the pixel position advances inside one 8-pixel cell. The colour outputs must be blank one cycle after an inactive pixel enters the pipeline. Every channel must sit at one of the three legal levels, and the channels must never mix normal and bright levels. Other behaviour can only be shown by the bench scenarios, which compare each pixel against a model of the memory contents. These cover the glyph bit order, the attribute field placement, the fallback to the default attribute, scroll wrap-around, the cursor swap and its absence in bitmap mode, and the two-cycle latency.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

   // attribute byte: background nibble high, foreground nibble low
   // nibble layout: {bright, blue, green, red}
   typedef struct packed {
      logic [3:0] bg;
      logic [3:0] fg;
   } vpg_attr_t;

   function automatic logic [2:0] vpg_level(input logic       on,
                                            input logic       hi,
                                            input logic [2:0] lvl_norm,
                                            input logic [2:0] lvl_bright);
      if (!on)
         return 3'd0;
      return hi ? lvl_bright : lvl_norm;
   endfunction

endpackage

// File: rtl/vpg_addr_gen.sv
module vpg_addr_gen #(
   parameter int XW       = 10,
   parameter int YW       = 10,
   parameter int AW       = 16,
   parameter int COLS     = 80,
   parameter int CELL_LG2 = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] pix_x,
   input  logic [YW-1:0] pix_y,
   input  logic          bitmap,
   input  logic [AW-1:0] scroll,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] line_idx;
   logic [AW-1:0] col_idx;

   // text mode counts character rows, bitmap mode counts pixel lines
   assign line_idx = bitmap ? AW'(pix_y) : AW'(pix_y >> CELL_LG2);
   assign col_idx  = AW'(pix_x >> CELL_LG2);
   assign addr     = line_idx * AW'(COLS) + col_idx + scroll;

   // R1: one fetch address covers a whole cell while x steps inside it
   p_cell_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_x[CELL_LG2-1:0] != '0 && pix_x == $past(pix_x) + 1'b1 &&
       pix_y == $past(pix_y) && $stable(scroll) && $stable(bitmap))
      |-> $stable(addr))
      else $error("fetch address moved inside a cell");

endmodule

// File: rtl/vpg_glyph_rom.sv
module vpg_glyph_rom #(
   parameter int CELL_LG2 = 3,
   parameter int VARIANT  = 0
) (
   input  logic [7:0]          code,
   input  logic [CELL_LG2-1:0] row,
   output logic [7:0]          bits
);

   generate
      if (VARIANT == 0) begin : g_rotate
         logic [15:0] dbl;
         assign dbl  = {code, code} << row;
         assign bits = dbl[15:8];
      end else begin : g_shift
         assign bits = code >> row;
      end
   endgenerate

endmodule

// File: rtl/vpg_shade.sv
module vpg_shade
   import vpg_pkg::*;
#(
   parameter int CELL_LG2   = 3,
   parameter int LVL_NORM   = 5,
   parameter int LVL_BRIGHT = 7
) (
   input  logic [7:0]          attr_raw,
   input  logic [7:0]          default_attr,
   input  logic                bitmap,
   input  logic                cursor,
   input  logic [7:0]          pix_byte,
   input  logic [CELL_LG2-1:0] col,
   output logic [2:0]          r,
   output logic [2:0]          g,
   output logic [2:0]          b
);

   localparam logic [CELL_LG2-1:0] LAST_COL = CELL_LG2'((1 << CELL_LG2) - 1);

   vpg_attr_t  eff;
   logic       lit;
   logic [3:0] nib;

   always_comb begin
      if (bitmap || attr_raw == 8'd0)
         eff = vpg_attr_t'(default_attr);
      else
         eff = vpg_attr_t'(attr_raw);
      lit = pix_byte[LAST_COL - col];
      nib = (lit != cursor) ? eff.fg : eff.bg;
   end

   assign r = vpg_level(nib[0], nib[3], 3'(LVL_NORM), 3'(LVL_BRIGHT));
   assign g = vpg_level(nib[1], nib[3], 3'(LVL_NORM), 3'(LVL_BRIGHT));
   assign b = vpg_level(nib[2], nib[3], 3'(LVL_NORM), 3'(LVL_BRIGHT));

endmodule

// File: rtl/vid_pixel_gen.sv
module vid_pixel_gen #(
   parameter int XW            = 10,
   parameter int YW            = 10,
   parameter int AW            = 16,
   parameter int COLS          = 80,
   parameter int ROWS          = 60,
   parameter int CELL_LG2      = 3,
   parameter int LVL_NORM      = 5,
   parameter int LVL_BRIGHT    = 7,
   parameter int CURSOR_EN     = 1,
   parameter int GLYPH_VARIANT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] pix_x,
   input  logic [YW-1:0] pix_y,
   input  logic          pix_de,
   input  logic          mode_bitmap,
   input  logic [AW-1:0] scroll_off,
   input  logic [AW-1:0] cursor_pos,
   input  logic [7:0]    default_attr,
   output logic [AW-1:0] mem_addr,
   input  logic [15:0]   mem_rdata,
   output logic [2:0]    vga_r,
   output logic [2:0]    vga_g,
   output logic [2:0]    vga_b
);

   localparam int CELL  = 1 << CELL_LG2;
   localparam int H_PIX = COLS * CELL;
   localparam int V_PIX = ROWS * CELL;

   generate
      if (CELL != 8) begin : g_bad_cell
         $error("a memory byte must cover exactly one cell row");
      end
      if ((1 << XW) < H_PIX || (1 << YW) < V_PIX) begin : g_bad_pos
         $error("position inputs too narrow for the raster");
      end
      if (LVL_NORM > 7 || LVL_BRIGHT > 7) begin : g_bad_lvl
         $error("colour levels exceed 3 bits");
      end
      if ((1 << AW) < COLS * V_PIX) begin : g_bad_aw
         $error("address too narrow for bitmap mode");
      end
   endgenerate

   // stage 0: fetch address
   vpg_addr_gen #(
      .XW(XW), .YW(YW), .AW(AW), .COLS(COLS), .CELL_LG2(CELL_LG2)
   ) u_addr (
      .clk(clk), .rst_n(rst_n),
      .pix_x(pix_x), .pix_y(pix_y),
      .bitmap(mode_bitmap), .scroll(scroll_off),
      .addr(mem_addr)
   );

   logic cursor_hit;
   generate
      if (CURSOR_EN != 0) begin : g_cursor
         assign cursor_hit = !mode_bitmap && (mem_addr == cursor_pos);
      end else begin : g_no_cursor
         assign cursor_hit = 1'b0;
      end
   endgenerate

   // stage 1: aligned with returning memory data
   logic                s1_de;
   logic                s1_bitmap;
   logic                s1_cursor;
   logic [CELL_LG2-1:0] s1_col;
   logic [CELL_LG2-1:0] s1_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_de     <= 1'b0;
         s1_bitmap <= 1'b0;
         s1_cursor <= 1'b0;
         s1_col    <= '0;
         s1_row    <= '0;
      end else begin
         s1_de     <= pix_de;
         s1_bitmap <= mode_bitmap;
         s1_cursor <= cursor_hit;
         s1_col    <= pix_x[CELL_LG2-1:0];
         s1_row    <= pix_y[CELL_LG2-1:0];
      end
   end

   logic [7:0] glyph_bits;
   logic [7:0] pix_byte;
   logic [2:0] nx_r, nx_g, nx_b;

   vpg_glyph_rom #(
      .CELL_LG2(CELL_LG2), .VARIANT(GLYPH_VARIANT)
   ) u_glyph (
      .code(mem_rdata[7:0]), .row(s1_row), .bits(glyph_bits)
   );

   assign pix_byte = s1_bitmap ? mem_rdata[7:0] : glyph_bits;

   vpg_shade #(
      .CELL_LG2(CELL_LG2), .LVL_NORM(LVL_NORM), .LVL_BRIGHT(LVL_BRIGHT)
   ) u_shade (
      .attr_raw(mem_rdata[15:8]), .default_attr(default_attr),
      .bitmap(s1_bitmap), .cursor(s1_cursor),
      .pix_byte(pix_byte), .col(s1_col),
      .r(nx_r), .g(nx_g), .b(nx_b)
   );

   // stage 2: output registers, blanked outside the active area
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vga_r <= 3'd0;
         vga_g <= 3'd0;
         vga_b <= 3'd0;
      end else if (!s1_de) begin
         vga_r <= 3'd0;
         vga_g <= 3'd0;
         vga_b <= 3'd0;
      end else begin
         vga_r <= nx_r;
         vga_g <= nx_g;
         vga_b <= nx_b;
      end
   end

   // R8: an inactive pixel in the pipeline gives black one edge later
   p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_de |=> (vga_r == 3'd0 && vga_g == 3'd0 && vga_b == 3'd0))
      else $error("colour outside active area");

   // R7: every channel sits on a legal level
   p_legal_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((vga_r == 3'd0 || vga_r == 3'(LVL_NORM) || vga_r == 3'(LVL_BRIGHT)) &&
       (vga_g == 3'd0 || vga_g == 3'(LVL_NORM) || vga_g == 3'(LVL_BRIGHT)) &&
       (vga_b == 3'd0 || vga_b == 3'(LVL_NORM) || vga_b == 3'(LVL_BRIGHT))))
      else $error("illegal colour level");

   // R7: one brightness bit drives all three channels of a pixel
   p_shared_bright_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vga_r == 3'(LVL_NORM) || vga_g == 3'(LVL_NORM) || vga_b == 3'(LVL_NORM))
      |-> (vga_r != 3'(LVL_BRIGHT) && vga_g != 3'(LVL_BRIGHT) &&
           vga_b != 3'(LVL_BRIGHT)))
      else $error("mixed brightness across channels");

endmodule

// File: tb/vid_pixel_gen_tb.sv
module vid_pixel_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [9:0]  pix_x;
   logic [9:0]  pix_y;
   logic        pix_de;
   logic        bm;
   logic [15:0] scroll;
   logic [15:0] cursor;
   logic [7:0]  dflt;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata;
   logic [2:0]  vga_r, vga_g, vga_b;

   always #4 clk = ~clk;

   vid_pixel_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
      .mode_bitmap(bm), .scroll_off(scroll), .cursor_pos(cursor),
      .default_attr(dflt),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
   );

   // video memory model, one cycle read latency
   logic [15:0] vram [4096];
   always @(posedge clk) mem_rdata <= vram[mem_addr[11:0]];

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   int          q_due [$];
   logic [8:0]  q_exp [$];
   string       q_tag [$];

   function automatic logic [15:0] fill_word(int a);
      logic [7:0] code, at;
      code = 8'(a * 7 + 3);
      at   = (a % 5 == 0) ? 8'd0 : 8'(a * 37 + 11);
      return {at, code};
   endfunction

   function automatic logic [2:0] lv(logic on, logic hi);
      return on ? (hi ? 3'd7 : 3'd5) : 3'd0;
   endfunction

   function automatic logic [8:0] model(int x, int y, bit de);
      logic [15:0] a, w, d;
      logic [7:0]  pb, at;
      logic [3:0]  nib;
      bit          on;
      if (!de) return 9'd0;
      if (bm) a = 16'(y * 80 + x / 8) + scroll;
      else    a = 16'((y / 8) * 80 + x / 8) + scroll;
      w = vram[a[11:0]];
      if (bm) begin
         pb = w[7:0];
         at = dflt;
      end else begin
         d  = {w[7:0], w[7:0]} << (y % 8);
         pb = d[15:8];
         at = (w[15:8] == 8'd0) ? dflt : w[15:8];
      end
      on = pb[7 - x % 8];
      if (!bm && a == cursor) on = !on;
      nib = on ? at[3:0] : at[7:4];
      return {lv(nib[0], nib[3]), lv(nib[1], nib[3]), lv(nib[2], nib[3])};
   endfunction

   // driver: one pixel per cycle, expected colour into the scoreboard
   task automatic drive(int x, int y, bit de, string tag);
      @(negedge clk);
      pix_x  = 10'(x);
      pix_y  = 10'(y);
      pix_de = de;
      q_due.push_back(cyc + 2);
      q_exp.push_back(model(x, y, de));
      q_tag.push_back(tag);
   endtask

   task automatic run_line(int y, int x0, int n, string tag);
      for (int i = 0; i < n; i++) drive(x0 + i, y, 1'b1, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pix_de = 1'b0;
      end
   endtask

   // monitor: pops the items due this cycle
   always @(posedge clk) begin
      cyc = cyc + 1;
      #2;
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         logic [8:0] act, exp;
         string      tag;
         act = {vga_r, vga_g, vga_b};
         exp = q_exp.pop_front();
         tag = q_tag.pop_front();
         void'(q_due.pop_front());
         checks++;
         if (act !== exp) begin
            errors++;
            $display("FAIL %s: rgb actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
         end
      end
   end

   initial begin
      for (int a = 0; a < 4096; a++) vram[a] = fill_word(a);
      rst_n  = 1'b0;
      pix_x  = '0;
      pix_y  = '0;
      pix_de = 1'b0;
      bm     = 1'b0;
      scroll = 16'd0;
      cursor = 16'h8000;
      dflt   = 8'h1E;
      repeat (4) @(negedge clk);
      checks++;
      if ({vga_r, vga_g, vga_b} !== 9'd0) begin
         errors++;
         $display("FAIL R11: rgb actual=%h expected=000", {vga_r, vga_g, vga_b});
      end
      rst_n = 1'b1;
      idle(2);

      // text rendering, latency, default fallback at addresses 0 and 5
      run_line(0, 0, 48, "R1 R2 R3 R4 R7 R10");
      run_line(13, 0, 48, "R1 R2 R3 R7");
      run_line(47, 600, 40, "R1 R2 R3");
      // blanking
      for (int i = 0; i < 16; i++) drive(i, 0, 1'b0, "R8");
      run_line(8, 0, 8, "R8 R10");
      idle(4);

      // scroll by one text row and with wrap-around
      scroll = 16'd80;
      run_line(0, 0, 32, "R5");
      idle(4);
      scroll = 16'hFFFE;
      run_line(3, 0, 24, "R5 wrap");
      idle(4);

      // cursor on address 3
      scroll = 16'd0;
      cursor = 16'd3;
      run_line(2, 16, 24, "R6");
      idle(4);
      scroll = 16'd80;
      cursor = 16'd84;
      run_line(5, 24, 24, "R6 R5");
      idle(4);

      // another default attribute
      scroll = 16'd0;
      cursor = 16'h8000;
      dflt   = 8'h9A;
      run_line(0, 0, 48, "R4");
      idle(4);

      // bitmap mode, cursor placed on a bitmap address must not show
      bm     = 1'b1;
      dflt   = 8'h2C;
      cursor = 16'd161;
      run_line(2, 0, 32, "R9 R6");
      run_line(3, 8, 24, "R9");
      idle(4);
      scroll = 16'd7;
      dflt   = 8'hF1;
      run_line(10, 40, 24, "R9 R5");
      for (int i = 0; i < 8; i++) drive(i, 10, 1'b0, "R8 R9");
      idle(6);

      if (q_due.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL R10: pending items actual=%0d expected=0", q_due.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycles actual=100000 expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule